// File: doc/BRIEF.md
# Queued Word-Aligned DMA Command Engine

This block is a small DMA engine that software drives through eight word-sized registers. Four of them describe a transfer: a source address, a destination address, a source length and a destination length. Lengths are given in words. Writing the destination-length register is the trigger. It captures all four values as one command and appends that command to a short in-order queue. The address and source-length values that are captured are the ones last written.

The engine takes commands from the queue head one at a time. It splits each command into bursts whose size is bounded by a parameter. In loopback mode, every burst is first read from the source into a local buffer and then written, word for word, to the destination. Outside loopback the engine only reads the source and discards the data.

When a command finishes, when a command is rejected, or when a push finds the queue full, the engine sets a flag in a write-one-to-clear status register. A mask register selects which flags drive the single interrupt output. The memory side is a plain request/acknowledge word port.

Top module: `wq_dma`

## Requirements
- R1: After reset, the flag register (index 4) reads 0, the mask register (index 5) reads 0xFFFFFFFF, the queue status register (index 6) reads 0x40000000 (empty, bit 30), `irq` is low and `mem_req` is low.
- R2: Register indices are 0 source address, 1 destination address, 2 source length, 3 destination length, 4 flags, 5 mask, 6 queue status, 7 mode. Only bits 26:0 of the two length registers are stored, and their upper bits read as zero. In the mode register only bit 4 (loopback) is stored. The queue status register ignores writes.
- R3: A write to index 3 enqueues one command. The command takes both addresses with bits 1:0 forced to zero, and both lengths shifted left by 2 to count bytes. Commands run in the order they were written, and every memory address the engine issues is word aligned.
- R4: A command moves data in bursts of at most BURST_BYTES, each limited by the remaining source length. Within a burst the address steps by 4 per word, and the next burst continues where the previous one stopped.
- R5: In loopback mode (mode bit 4 set when the command starts), each burst reads all of its source words and then writes the same data, in the same order, to consecutive destination words.
- R6: Outside loopback mode the engine issues only reads (`mem_we` low), covering the whole source length.
- R7: When both remaining lengths reach zero, flag bits 13 (done) and 12 (partial done) are set and the command leaves the queue. A command with both lengths zero completes this way with no memory access.
- R8: A command whose destination length is nonzero outside loopback, or whose two lengths differ in loopback, sets flag bit 15 (command error). The command is then dropped with no memory access and no done flags.
- R9: The queue holds QDEPTH commands, including the one running. Status bit 31 reports full. A push while full is dropped and sets flag bit 14 (overflow).
- R10: Writing a 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R11: `irq` is high exactly when some flag bit is set whose mask bit is 0.
- R12: Once `mem_req` is raised, it stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until a cycle with `mem_ack` high. That cycle completes one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Completes the pending word |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the engine with BURST_BYTES = 16, which gives four-word bursts. A ten-word loopback copy therefore splits into bursts of four, four and two words. That puts the burst boundary, the read-then-write order inside each burst and the short final burst within a short run. QDEPTH stays at 4. The bench stalls its memory responder so that four commands fill the queue and a fifth overflows, and so that the request can be seen holding steady while no acknowledge arrives.

// File: rtl/wq_dma_pkg.sv
// Shared widths, register indices, flag positions and the command record
// for the queued DMA engine. Assumes 32-bit words and byte addresses.
package wq_dma_pkg;
    localparam int AW     = 32;          // address and data width
    localparam int LEN_W  = 27;          // writable bits of a length register
    localparam int BLEN_W = LEN_W + 2;   // length in bytes

    localparam logic [2:0] IDX_SRC    = 3'd0;
    localparam logic [2:0] IDX_DST    = 3'd1;
    localparam logic [2:0] IDX_SLEN   = 3'd2;
    localparam logic [2:0] IDX_DLEN   = 3'd3;
    localparam logic [2:0] IDX_FLAGS  = 3'd4;
    localparam logic [2:0] IDX_MASK   = 3'd5;
    localparam logic [2:0] IDX_STATUS = 3'd6;
    localparam logic [2:0] IDX_MODE   = 3'd7;

    localparam int FLAG_LO   = 12;   // flags occupy bits 15:12
    localparam int BIT_LOOP  = 4;
    localparam int BIT_FULL  = 31;
    localparam int BIT_EMPTY = 30;

    typedef struct packed {
        logic [AW-1:0]     saddr;
        logic [AW-1:0]     daddr;
        logic [BLEN_W-1:0] slen;
        logic [BLEN_W-1:0] dlen;
    } dma_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_READ, ST_WRITE, ST_ADV
    } mv_state_t;
endpackage

// File: rtl/wq_dma_fifo.sv
// In-order command queue. The head stays visible until the mover pops it,
// so the running command occupies a slot. Pushes while full are ignored
// here; the caller flags them. Assumes push and pop are single-cycle strobes.
module wq_dma_fifo
    import wq_dma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  dma_cmd_t cmd_i,
    input  logic     pop_i,
    output dma_cmd_t head_o,
    output logic     full_o,
    output logic     empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    dma_cmd_t       slots [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [CW-1:0]  cnt;
    logic           do_push, do_pop;

    assign full_o  = (cnt == CW'(DEPTH));
    assign empty_o = (cnt == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = slots[rp];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // Command storage, no reset needed.
    always_ff @(posedge clk) begin
        if (do_push) slots[wp] <= cmd_i;
    end

    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/wq_dma_mover.sv
// Executes the queue head: checks the lengths, then runs bursts of at most
// BURST_BYTES. Each burst reads into a local buffer and, in loopback, writes
// the buffer back out. Assumes BURST_BYTES is a multiple of 4 and at least 8.
module wq_dma_mover
    import wq_dma_pkg::*;
#(
    parameter int BURST_BYTES = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dma_cmd_t      head_i,
    input  logic          have_cmd_i,
    input  logic          loop_i,
    output logic          pop_o,
    output logic          done_o,
    output logic          err_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [AW-1:0] mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [AW-1:0] mem_rdata_i
);
    localparam int BW = BURST_BYTES / 4;
    localparam int IW = (BW > 1) ? $clog2(BW) : 1;
    localparam int CW = $clog2(BW + 1);

    mv_state_t         state;
    logic [AW-1:0]     saddr, daddr;
    logic [BLEN_W-1:0] slen, dlen, btt, nb;
    logic              loop_l, bad, last;
    logic [IW-1:0]     idx;
    logic [CW-1:0]     nw;
    logic [AW-1:0]     buf_q [BW];

    // Burst size and command sanity.
    always_comb begin
        btt = (slen < BLEN_W'(BURST_BYTES)) ? slen : BLEN_W'(BURST_BYTES);
        if (loop_l && dlen < btt) btt = dlen;
        bad = loop_l ? (slen != dlen) : (dlen != '0);
    end

    assign nb     = BLEN_W'({nw, 2'b00});
    assign last   = (CW'(idx) == nw - CW'(1));
    assign err_o  = (state == ST_CHECK) && bad;
    assign done_o = (state == ST_CHECK) && !bad && (slen == '0);
    assign pop_o  = err_o || done_o;

    assign mem_req_o   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we_o    = (state == ST_WRITE);
    assign mem_addr_o  = ((state == ST_WRITE) ? daddr : saddr) + AW'({idx, 2'b00});
    assign mem_wdata_o = buf_q[idx];

    // Command sequencing and burst progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            saddr  <= '0;
            daddr  <= '0;
            slen   <= '0;
            dlen   <= '0;
            loop_l <= 1'b0;
            idx    <= '0;
            nw     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (have_cmd_i) begin
                    saddr  <= head_i.saddr;
                    daddr  <= head_i.daddr;
                    slen   <= head_i.slen;
                    dlen   <= head_i.dlen;
                    loop_l <= loop_i;
                    state  <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (bad || slen == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        nw    <= btt[CW+1:2];
                        idx   <= '0;
                        state <= ST_READ;
                    end
                end
                ST_READ: if (mem_ack_i) begin
                    if (last) begin
                        idx   <= '0;
                        state <= loop_l ? ST_WRITE : ST_ADV;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                ST_WRITE: if (mem_ack_i) begin
                    if (last) state <= ST_ADV;
                    else      idx   <= idx + IW'(1);
                end
                ST_ADV: begin
                    saddr <= saddr + AW'(nb);
                    slen  <= slen - nb;
                    if (loop_l) begin
                        daddr <= daddr + AW'(nb);
                        dlen  <= dlen - nb;
                    end
                    state <= ST_CHECK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Burst buffer capture on each read acknowledge.
    always_ff @(posedge clk) begin
        if (state == ST_READ && mem_ack_i) buf_q[idx] <= mem_rdata_i;
    end

    assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o));
    assert_write_only_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> loop_l);
    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);
endmodule

// File: rtl/wq_dma.sv
// Top of the queued DMA engine: register file, flag and mask logic, and the
// interrupt. A write to the destination-length index builds and pushes a
// command. Assumes one register access per cycle and a combinational read.
module wq_dma
    import wq_dma_pkg::*;
#(
    parameter int BURST_BYTES = 1024,
    parameter int QDEPTH      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        irq
);
    logic [AW-1:0]    r_src, r_dst, r_mask;
    logic [LEN_W-1:0] r_slen, r_dlen;
    logic             r_loop;
    logic [3:0]       r_flag, flag_clr, flag_set;
    logic [31:0]      flags32, status32;
    logic             push, ovf, q_full, q_empty, mv_pop, mv_done, mv_err;
    dma_cmd_t         new_cmd, head;

    assign push = reg_we && (reg_addr == IDX_DLEN);
    assign ovf  = push && q_full;

    assign new_cmd.saddr = {r_src[AW-1:2], 2'b00};
    assign new_cmd.daddr = {r_dst[AW-1:2], 2'b00};
    assign new_cmd.slen  = {r_slen, 2'b00};
    assign new_cmd.dlen  = {reg_wdata[LEN_W-1:0], 2'b00};

    wq_dma_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .cmd_i(new_cmd),
        .pop_i(mv_pop), .head_o(head), .full_o(q_full), .empty_o(q_empty)
    );

    wq_dma_mover #(.BURST_BYTES(BURST_BYTES)) u_mover (
        .clk(clk), .rst_n(rst_n), .head_i(head), .have_cmd_i(!q_empty),
        .loop_i(r_loop), .pop_o(mv_pop), .done_o(mv_done), .err_o(mv_err),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
    );

    // Flag set and write-one-to-clear terms; order is bits 15..12.
    always_comb begin
        flag_clr = (reg_we && reg_addr == IDX_FLAGS) ? reg_wdata[FLAG_LO+3:FLAG_LO] : 4'b0;
        flag_set = {mv_err, ovf, mv_done, mv_done};
    end

    // Software-visible register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_src  <= '0;
            r_dst  <= '0;
            r_slen <= '0;
            r_dlen <= '0;
            r_mask <= '1;
            r_loop <= 1'b0;
            r_flag <= '0;
        end else begin
            r_flag <= (r_flag & ~flag_clr) | flag_set;
            if (reg_we) begin
                case (reg_addr)
                    IDX_SRC:  r_src  <= reg_wdata;
                    IDX_DST:  r_dst  <= reg_wdata;
                    IDX_SLEN: r_slen <= reg_wdata[LEN_W-1:0];
                    IDX_DLEN: r_dlen <= reg_wdata[LEN_W-1:0];
                    IDX_MASK: r_mask <= reg_wdata;
                    IDX_MODE: r_loop <= reg_wdata[BIT_LOOP];
                    default: ;
                endcase
            end
        end
    end

    assign flags32  = {16'b0, r_flag, 12'b0};
    assign status32 = {q_full, q_empty, 30'b0};
    assign irq      = |(flags32 & ~r_mask);

    // Register read mux.
    always_comb begin
        case (reg_addr)
            IDX_SRC:    reg_rdata = r_src;
            IDX_DST:    reg_rdata = r_dst;
            IDX_SLEN:   reg_rdata = {{(32-LEN_W){1'b0}}, r_slen};
            IDX_DLEN:   reg_rdata = {{(32-LEN_W){1'b0}}, r_dlen};
            IDX_FLAGS:  reg_rdata = flags32;
            IDX_MASK:   reg_rdata = r_mask;
            IDX_STATUS: reg_rdata = status32;
            default:    reg_rdata = {27'b0, r_loop, 4'b0};
        endcase
    end

    assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push && q_full |=> r_flag[2]);
    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_done |=> r_flag[1] && r_flag[0]);
    assert_err_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mv_err |-> !mv_done);
    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (&r_mask) |-> !irq);
endmodule

// File: tb/sim_wq_dma.sv
module sim_wq_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    bit stall = 1'b0;
    bit finished = 1'b0;

    logic [31:0] mem [256];
    int          nops;
    logic        op_we   [256];
    logic [31:0] op_addr [256];

    always #10 clk = ~clk;

    wq_dma #(.BURST_BYTES(16), .QDEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    // Memory responder: one acknowledge per request, two cycles per word.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            nops      <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= 32'hC0DE0000 | i;
        end else if (mem_req && !mem_ack && !stall) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
            op_we[nops[7:0]]   <= mem_we;
            op_addr[nops[7:0]] <= mem_addr;
            nops <= nops + 1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(3'd6, s);
            if (s[30]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic launch(input logic [31:0] src, dst, slen, dlen);
        wr(3'd0, src); wr(3'd1, dst); wr(3'd2, slen); wr(3'd3, dlen);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd4, v); chk("R1 flags", v, 32'h0);
        rd(3'd5, v); chk("R1 mask", v, 32'hFFFFFFFF);
        rd(3'd6, v); chk("R1 status", v, 32'h40000000);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(3'd2, 32'hFFFFFFFF); rd(3'd2, v); chk("R2 length width", v, 32'h07FFFFFF);
        wr(3'd7, 32'hFFFFFFFF); rd(3'd7, v); chk("R2 mode bits", v, 32'h00000010);
        wr(3'd6, 32'h0);        rd(3'd6, v); chk("R2 status read-only", v, 32'h40000000);
        wr(3'd7, 32'h0);
    endtask

    task automatic t_loopback();
        logic [31:0] v;
        int base, k, bad;
        base = nops;
        wr(3'd7, 32'h10);
        launch(32'h41, 32'h203, 32'd10, 32'd10);
        wait_idle();
        chk("R4 op count", nops - base, 32'd20);
        k = base; bad = 0;
        for (int b = 0; b < 10; b += 4) begin
            int n = (10 - b < 4) ? 10 - b : 4;
            for (int j = 0; j < n; j++) begin
                if (op_we[k] !== 1'b0 || op_addr[k] !== 32'h40 + 4 * (b + j)) bad++;
                k++;
            end
            for (int j = 0; j < n; j++) begin
                if (op_we[k] !== 1'b1 || op_addr[k] !== 32'h200 + 4 * (b + j)) bad++;
                k++;
            end
        end
        chk("R5 R4 R3 burst order and aligned addresses", bad, 0);
        bad = 0;
        for (int j = 0; j < 10; j++)
            if (mem[128 + j] !== (32'hC0DE0000 | (16 + j))) bad++;
        chk("R5 copied data", bad, 0);
        rd(3'd4, v); chk("R7 done flags", v, 32'h00003000);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        wr(3'd5, ~32'h00002000); rd(3'd4, v);
        chk("R11 irq unmasked", {31'b0, irq}, 32'h1);
        wr(3'd4, 32'h0); rd(3'd4, v); chk("R10 write zero keeps", v, 32'h00003000);
        wr(3'd4, 32'h1000); rd(3'd4, v); chk("R10 clear bit 12", v, 32'h00002000);
        wr(3'd4, 32'h2000); rd(3'd4, v); chk("R10 clear bit 13", v, 32'h0);
        chk("R11 irq drops", {31'b0, irq}, 32'h0);
        wr(3'd5, 32'hFFFFFFFF);
        wr(3'd7, 32'h0);
    endtask

    task automatic t_read_only();
        logic [31:0] v;
        int base, bad;
        base = nops;
        launch(32'h100, 32'h300, 32'd6, 32'd0);
        wait_idle();
        chk("R6 read count", nops - base, 32'd6);
        bad = 0;
        for (int j = 0; j < 6; j++)
            if (op_we[base + j] !== 1'b0 || op_addr[base + j] !== 32'h100 + 4 * j) bad++;
        chk("R6 R4 reads only, consecutive", bad, 0);
        rd(3'd4, v); chk("R7 done after read-only", v, 32'h00003000);
        wr(3'd4, 32'hF000);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        int base;
        base = nops;
        launch(32'h0, 32'h0, 32'd2, 32'd3);
        wait_idle();
        rd(3'd4, v); chk("R8 error non-loopback", v, 32'h00008000);
        wr(3'd4, 32'hF000);
        wr(3'd7, 32'h10);
        launch(32'h0, 32'h0, 32'd2, 32'd3);
        wait_idle();
        rd(3'd4, v); chk("R8 error loopback mismatch", v, 32'h00008000);
        chk("R8 no memory access", nops - base, 32'd0);
        wr(3'd4, 32'hF000);
        wr(3'd7, 32'h0);
        launch(32'h0, 32'h0, 32'd0, 32'd0);
        wait_idle();
        rd(3'd4, v); chk("R7 zero length done", v, 32'h00003000);
        chk("R7 zero length no access", nops - base, 32'd0);
        wr(3'd4, 32'hF000);
    endtask

    task automatic t_queue();
        logic [31:0] v, a0;
        int base, bad;
        base = nops;
        stall = 1'b1;
        for (int i = 0; i < 4; i++) launch(32'h80 + 32'h10 * i, 32'h0, 32'd1, 32'd0);
        rd(3'd6, v); chk("R9 full status", v, 32'h80000000);
        launch(32'hF0, 32'h0, 32'd1, 32'd0);
        rd(3'd4, v); chk("R9 overflow flag", v, 32'h00004000);
        @(negedge clk); a0 = mem_addr;
        repeat (5) @(negedge clk);
        chk("R12 request held", {31'b0, mem_req}, 32'h1);
        chk("R12 address stable", mem_addr, a0);
        stall = 1'b0;
        wait_idle();
        chk("R9 executed count", nops - base, 32'd4);
        bad = 0;
        for (int i = 0; i < 4; i++)
            if (op_addr[base + i] !== 32'h80 + 32'h10 * i) bad++;
        chk("R3 queue order", bad, 0);
        rd(3'd6, v); chk("R9 empty again", v, 32'h40000000);
        wr(3'd4, 32'hF000);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_loopback();
        t_read_only();
        t_errors();
        t_queue();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        summary();
    end
endmodule